// File: doc/BRIEF.md
# Burst Address Generator

This block produces the word address for a synchronous burst memory. A 16-bit external address is captured on a rising clock edge when one of two active-low address strobes is asserted. After that, a 2-bit beat counter supplies the two lowest address bits through a four-beat burst. The upper fourteen bits keep the value that was loaded.

The processor strobe loads only while the primary chip enable (active low) is asserted. The controller strobe loads regardless of the chip enable.

On cycles without a load, the advance input controls the counter:

- When advance is low, the counter steps forward by one.
- When advance is high, the counter holds and the cycle is a wait cycle.

A static mode input selects the order of the two low bits. Low selects linear order (base plus beat). High selects interleaved order (base XOR beat). A one-cycle flag marks the first beat of each burst.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_ni is low, and after it is released with no further stimulus, addr_o is 16'h0000 and burst_start_o is 0.
- R2: When ads_proc_ni is 0 and chip_en_ni is 0 at a rising edge, addr_o equals the sampled addr_i from that edge on, and the beat count restarts at 0.
- R3: When ads_proc_ni is 0, chip_en_ni is 1 and ads_ctrl_ni is 1, no load occurs. The cycle then behaves as an advance or a wait cycle, according to adv_ni.
- R4: When ads_ctrl_ni is 0 at a rising edge, addr_i is loaded and the beat count restarts at 0, whatever the value of chip_en_ni.
- R5: A load takes priority over advance. A load in the middle of a burst restarts the beat count at 0.
- R6: On a non-load edge with adv_ni at 0, the beat count increments modulo 4 and addr_o[15:2] is unchanged.
- R7: On a non-load edge with adv_ni at 1, addr_o is held (wait cycle).
- R8: With mode_i at 0, addr_o[1:0] equals (loaded bits [1:0] + beat) mod 4.
- R9: With mode_i at 1, addr_o[1:0] equals loaded bits [1:0] XOR beat.
- R10: burst_start_o is 1 in exactly the cycle that follows a load edge, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | External address |
| ads_proc_ni | input | 1 | Processor address strobe, active low |
| ads_ctrl_ni | input | 1 | Controller address strobe, active low |
| chip_en_ni | input | 1 | Primary chip enable, active low; gates the processor strobe |
| adv_ni | input | 1 | Burst advance, active low |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| addr_o | output | 16 | Current word address |
| burst_start_o | output | 1 | High in the first beat after a load |

## Verification
The hardest case to reach is a sequence that mixes wait cycles, a counter wrap after the fourth advance, and a new load that lands mid-burst. A second hard case is a processor strobe that is blocked by the chip enable and must fall through to advance or wait. Directed sequences drive each of these cases in both burst orders. A long random run then draws the strobes, the chip enable and the advance input with low-probability loads, so that bursts run long enough to wrap and are often cut short. The mode input is changed only on load cycles.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned BEAT_W = 2;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_STEP = 2'd1,
    OP_LOAD = 2'd2
  } burst_op_e;
endpackage

// File: rtl/burst_load_ctl.sv
module burst_load_ctl
  import burst_pkg::*;
(
  input  logic      ads_proc_ni,
  input  logic      ads_ctrl_ni,
  input  logic      chip_en_ni,
  input  logic      adv_ni,
  output burst_op_e op_o
);
  logic proc_load, ctrl_load;

  assign proc_load = !ads_proc_ni && !chip_en_ni;
  assign ctrl_load = !ads_ctrl_ni;

  always_comb begin
    if (proc_load || ctrl_load) op_o = OP_LOAD;
    else if (!adv_ni)           op_o = OP_STEP;
    else                        op_o = OP_HOLD;
  end
endmodule

// File: rtl/burst_counter.sv
module burst_counter
  import burst_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned BW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  burst_op_e     op_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] base_o,
  output logic [BW-1:0] beat_o,
  output logic          start_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o  <= '0;
      beat_o  <= '0;
      start_o <= 1'b0;
    end else begin
      start_o <= (op_i == OP_LOAD);
      unique case (op_i)
        OP_LOAD: begin
          base_o <= addr_i;
          beat_o <= '0;
        end
        OP_STEP: beat_o <= beat_o + 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/burst_order.sv
module burst_order #(
  parameter int unsigned BW = 2
) (
  input  logic          mode_i,
  input  logic [BW-1:0] base_lo_i,
  input  logic [BW-1:0] beat_i,
  output logic [BW-1:0] lo_o
);
  logic [BW-1:0] lin, ilv;

  assign lin = base_lo_i + beat_i;

  for (genvar b = 0; b < BW; b++) begin : g_ilv
    assign ilv[b] = base_lo_i[b] ^ beat_i[b];
  end

  assign lo_o = mode_i ? ilv : lin;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned BW = BEAT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          ads_proc_ni,
  input  logic          ads_ctrl_ni,
  input  logic          chip_en_ni,
  input  logic          adv_ni,
  input  logic          mode_i,
  output logic [AW-1:0] addr_o,
  output logic          burst_start_o
);
  localparam int unsigned HI_W = AW - BW;

  burst_op_e     op;
  logic [AW-1:0] base;
  logic [BW-1:0] beat;
  logic [BW-1:0] lo;

  burst_load_ctl u_ctl (
    .ads_proc_ni (ads_proc_ni),
    .ads_ctrl_ni (ads_ctrl_ni),
    .chip_en_ni  (chip_en_ni),
    .adv_ni      (adv_ni),
    .op_o        (op)
  );

  burst_counter #(.AW(AW), .BW(BW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .addr_i  (addr_i),
    .base_o  (base),
    .beat_o  (beat),
    .start_o (burst_start_o)
  );

  burst_order #(.BW(BW)) u_ord (
    .mode_i    (mode_i),
    .base_lo_i (base[BW-1:0]),
    .beat_i    (beat),
    .lo_o      (lo)
  );

  assign addr_o = {base[AW-1:AW-HI_W], lo};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned BW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          ads_proc_ni,
  input logic          ads_ctrl_ni,
  input logic          chip_en_ni,
  input logic          adv_ni,
  input logic          mode_i,
  input logic [AW-1:0] addr_o,
  input logic          burst_start_o
);
  logic load;
  assign load = (!ads_proc_ni && !chip_en_ni) || !ads_ctrl_ni;

  assert_proc_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ads_proc_ni && !chip_en_ni) |=> (addr_o == $past(addr_i)));

  assert_ctrl_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ads_ctrl_ni |=> (addr_o == $past(addr_i)));

  assert_blocked_wait_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ads_proc_ni && chip_en_ni && ads_ctrl_ni && adv_ni)
      |=> ($stable(addr_o) || !$stable(mode_i)));

  assert_upper_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> (addr_o[AW-1:BW] == $past(addr_o[AW-1:BW])));

  assert_wait_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load && adv_ni) |=> ($stable(addr_o) || !$stable(mode_i)));

  assert_start_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> burst_start_o);

  assert_start_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> !burst_start_o);
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW), .BW(BW)) u_chk (.*);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic        ads_proc_ni = 1'b1, ads_ctrl_ni = 1'b1, chip_en_ni = 1'b1;
  logic        adv_ni = 1'b1, mode_i = 1'b0;
  logic [15:0] addr_o;
  logic        burst_start_o;

  int checks = 0, failures = 0;
  logic [15:0] m_base = '0;
  logic [1:0]  m_beat = '0;
  logic        m_start = 1'b0;

  always #5 clk_i = ~clk_i;

  burst_addr_gen u_dut (.*);

  function automatic logic [15:0] exp_addr(logic [15:0] b, logic [1:0] t, logic m);
    logic [1:0] lo;
    lo = m ? (b[1:0] ^ t) : (b[1:0] + t);
    return {b[15:2], lo};
  endfunction

  task automatic check(string tag, logic [16:0] act, logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic [15:0] a, logic p, logic c, logic ce, logic adv, logic m, string tag);
    logic ld;
    @(negedge clk_i);
    addr_i = a; ads_proc_ni = p; ads_ctrl_ni = c; chip_en_ni = ce; adv_ni = adv; mode_i = m;
    @(posedge clk_i);
    ld = (!p && !ce) || !c;
    m_start = ld;
    if (ld) begin m_base = a; m_beat = 2'd0; end
    else if (!adv) m_beat = m_beat + 2'd1;
    #1;
    check(tag, {burst_start_o, addr_o}, {m_start, exp_addr(m_base, m_beat, m)});
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic m;
    seed = 32'd1234;
    void'($urandom(seed));
    #2;
    check("R1 in reset", {burst_start_o, addr_o}, 17'h0);
    #20 rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after reset", {burst_start_o, addr_o}, 17'h0);

    // linear burst with waits and wrap
    step(16'h1235, 0, 1, 0, 1, 0, "R2 proc load");
    step(16'h0, 1, 1, 1, 0, 0, "R6 R8 step");
    step(16'h0, 1, 1, 1, 1, 0, "R7 wait");
    step(16'h0, 1, 1, 1, 0, 0, "R8 step");
    step(16'h0, 1, 1, 1, 0, 0, "R8 step");
    step(16'h0, 1, 1, 1, 0, 0, "R6 wrap");
    // interleaved burst
    step(16'hABCE, 1, 0, 1, 1, 1, "R4 ctrl load ce high");
    for (int i = 0; i < 4; i++) step(16'h0, 1, 1, 1, 0, 1, "R9 interleave");
    // mid-burst reload with advance low
    step(16'h4441, 0, 1, 0, 0, 1, "R2 load");
    step(16'h0, 1, 1, 1, 0, 1, "R9 step");
    step(16'h7777, 0, 0, 0, 0, 1, "R5 reload mid-burst");
    step(16'h0, 1, 1, 0, 0, 1, "R9 step");
    // blocked proc strobe
    step(16'hFFFF, 0, 1, 1, 1, 1, "R3 blocked wait");
    step(16'hFFFF, 0, 1, 1, 0, 1, "R3 blocked step");
    step(16'h0003, 1, 0, 0, 0, 0, "R4 ctrl load");
    for (int i = 0; i < 5; i++) step(16'h0, 1, 1, 1, 0, 0, "R8 linear from 3");

    m = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      logic p, c, ce, adv;
      p   = ($urandom_range(0, 7) != 0);
      c   = ($urandom_range(0, 9) != 0);
      ce  = $urandom_range(0, 1);
      adv = ($urandom_range(0, 3) == 0);
      if ((!p && !ce) || !c) m = $urandom_range(0, 1);
      step(16'($urandom), p, c, ce, adv, m, "R5 R6 R7 R10 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule